// File: doc/BRIEF.md
# Ethernet transmit status tracker

This block keeps the per-frame status word of a half-duplex Ethernet MAC transmitter. The transmit engine reports events to it as single-cycle strobes and levels: frame start and end, collisions, the preamble-end carrier check, deferral and inter-frame-gap activity, frame type, and the signal-quality test pulse. It also sees a bank of 4-bit event counters. Every status bit has its own set condition and its own clear condition. The clear conditions are frame start, frame end, a successful frame end, software setting transmit enable again, or a read of the counter register.

The block also owns the transmit-enable bit. Software sets and clears it through request strobes. When software clears it, the frame in progress still finishes. When a fatal error occurs (lost carrier, late collision or sixteen collisions), the block drops the bit by itself. A late collision first raises a one-cycle jam request towards the engine.

At every frame completion, the block copies the status word to a snapshot output with a one-cycle valid strobe, so it can be stored as the first word of the packet's buffer. The link pin is active-low. It is inverted into a link bit, and any change of that bit raises a one-cycle interrupt. Byte times come from `tick_i`.

Top module: `tx_stat_tracker`

## Requirements
- R1: While `rst_ni` is low, every status bit, `txen_o`, `jam_o`, `snap_valid_o` and `link_irq_o` are zero. The status layout is: bit0 success, bit1 multiple collisions, bit2 broadcast, bit3 multicast, bit4 deferred, bit5 excessive deferral, bit6 late collision, bit7 lost carrier, bit8 sixteen collisions, bit9 SQE error, bit10 counter rollover, bit11 link OK, bit12 transmit enable.
- R2: Bit11 follows the inverse of `link_ni`, with one register delay. `link_irq_o` pulses for one cycle in the same cycle that bit11 changes.
- R3: Bit10 sets on the cycle after any 4-bit field of `evt_counts_i` newly becomes 15. It stays set until `cnt_read_i` is seen. A read while a field stays at 15 clears the bit, and the bit does not set again until a field newly reaches 15.
- R4: Bit5 sets once `defer_i` has been high for more than 2×MAX_FRAME_BYTES ticks (3036 by default) since the last frame end. It clears, together with that count, at `frame_end_i`.
- R5: Bit4 sets when `carrier_i` is high while `ifg_i` is high and fewer than EARLY_IFG_BYTES ticks (80) have passed in the current gap. Carrier later in the gap has no effect. The bit clears at `frame_end_i`.
- R6: Bit7 sets on `preamble_end_i` with `mon_carrier_i` high and `carrier_i` low, and is ignored when `mon_carrier_i` is low. Bit8 sets on the 16th collision of a frame. Either event clears `txen_o`. Bits 6, 7, 8 and 9 clear only on `txen_set_i`.
- R7: A collision more than LATE_COL_BYTES (64) ticks after frame start sets bit6 and pulses `jam_o` for one cycle. `txen_o` clears on the following cycle.
- R8: At `frame_end_i`, bit2 and bit3 record `bcast_i` and `mcast_i`. Both clear at `frame_start_i`.
- R9: Bit1 sets on the second collision of a frame. It clears at a frame end that sets bit0.
- R10: When `full_duplex_i` is low and `sqe_test_en_i` is high, bit9 sets at `frame_end_i` if no `sqe_pulse_i` was seen since the frame started. In full duplex it never sets.
- R11: `txen_clr_i` during a frame keeps `txen_o` high until that frame's `frame_end_i`. Outside a frame it clears `txen_o` on the next cycle.
- R12: The cycle after `frame_end_i`, `snap_valid_o` is high for one cycle. `snap_o` then holds the status word including that frame's set events, taken before the end-of-frame clears.
- R13: Bit0 sets at `frame_end_i` when no late collision, lost carrier or sixteenth collision occurred in the frame. It clears at `frame_start_i`.
- R14: Bits 15 to 13 of `status_o` and `snap_o` are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One byte time elapsed |
| frame_start_i | input | 1 | Transmit frame starts |
| frame_end_i | input | 1 | Transmit frame completes |
| collision_i | input | 1 | Collision seen |
| preamble_end_i | input | 1 | End of preamble reached |
| carrier_i | input | 1 | Carrier sense level |
| mon_carrier_i | input | 1 | Enable the lost-carrier check |
| defer_i | input | 1 | Transmitter is deferring |
| ifg_i | input | 1 | Inter-frame gap in progress |
| bcast_i | input | 1 | Current frame is broadcast |
| mcast_i | input | 1 | Current frame is multicast |
| full_duplex_i | input | 1 | Full-duplex mode |
| sqe_test_en_i | input | 1 | Enable SQE error reporting |
| sqe_pulse_i | input | 1 | SQE test pulse received |
| evt_counts_i | input | 4*NUM_CNT | Packed 4-bit event counters |
| cnt_read_i | input | 1 | Counter register read |
| txen_set_i | input | 1 | Software sets transmit enable |
| txen_clr_i | input | 1 | Software clears transmit enable |
| link_ni | input | 1 | Link pin, active low |
| status_o | output | 16 | Live status word |
| snap_o | output | 16 | Status snapshot at frame end |
| snap_valid_o | output | 1 | Snapshot valid strobe |
| txen_o | output | 1 | Transmit enable |
| jam_o | output | 1 | Jam request after late collision |
| link_irq_o | output | 1 | Link change interrupt |

## Verification
The assertions check, on every cycle, the relations that can be stated between neighbouring cycles:
- the link interrupt coincides with a change of the link bit;
- transmit enable is low whenever a fatal bit rises or a jam has just been issued;
- the lost-carrier bit is sticky until a set request;
- the snapshot strobe follows each frame end;
- the success bit is clear after each frame start;
- the rollover bit holds until a read.

Only the bench scenarios can show the properties that depend on long windows or sequences:
- the deferral thresholds at exactly 3036 and 3037 ticks;
- the early-gap window;
- the deferred stop of transmit enable at the end of a frame;
- the snapshot contents;
- the SQE behaviour across duplex settings.

// File: rtl/tx_stat_pkg.sv
package tx_stat_pkg;
  localparam int STAT_W = 16;
  localparam int STICKY_N = 11;
  typedef logic [STAT_W-1:0] stat_word_t;

  localparam int B_OK    = 0;
  localparam int B_MULTI = 1;
  localparam int B_BCAST = 2;
  localparam int B_MCAST = 3;
  localparam int B_DEFER = 4;
  localparam int B_EXCDF = 5;
  localparam int B_LATE  = 6;
  localparam int B_LOST  = 7;
  localparam int B_COL16 = 8;
  localparam int B_SQE   = 9;
  localparam int B_ROLL  = 10;
  localparam int B_LINK  = 11;
  localparam int B_TXEN  = 12;
endpackage

// File: rtl/sat_tick_cnt.sv
module sat_tick_cnt #(
  parameter int MAX = 64,
  localparam int W = $clog2(MAX + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] CMAX = W'(MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_o <= '0;
    else if (clr_i)                  cnt_o <= '0;
    else if (en_i && cnt_o != CMAX)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/tx_col_track.sv
module tx_col_track #(
  parameter int LATE_COL_BYTES = 64,
  parameter int MAX_COL = 16,
  localparam int BW = $clog2(LATE_COL_BYTES + 2),
  localparam int CW = $clog2(MAX_COL + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_start_i,
  input  logic          in_frame_i,
  input  logic          collision_i,
  input  logic [BW-1:0] frame_bytes_i,
  output logic          multi_set_o,
  output logic          col16_set_o,
  output logic          late_set_o,
  output logic          jam_o
);
  localparam logic [CW-1:0] CMAX = CW'(MAX_COL);
  localparam logic [BW-1:0] LATE = BW'(LATE_COL_BYTES);

  logic [CW-1:0] col_cnt_q;
  logic          col_hit;

  assign col_hit = collision_i && in_frame_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        col_cnt_q <= '0;
    else if (frame_start_i)             col_cnt_q <= '0;
    else if (col_hit && col_cnt_q != CMAX) col_cnt_q <= col_cnt_q + 1'b1;
  end

  assign multi_set_o = col_hit && (col_cnt_q != '0);
  assign col16_set_o = col_hit && (col_cnt_q == CMAX - 1'b1);
  assign late_set_o  = col_hit && (frame_bytes_i > LATE);

  // jam goes out one cycle ahead of the enable drop
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) jam_o <= 1'b0;
    else         jam_o <= late_set_o;
  end
endmodule

// File: rtl/tx_txen_ctl.sv
module tx_txen_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic fatal_i,
  input  logic in_frame_i,
  input  logic frame_end_i,
  output logic txen_o
);
  logic stop_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txen_o      <= 1'b0;
      stop_pend_q <= 1'b0;
    end else if (fatal_i) begin
      txen_o      <= 1'b0;
      stop_pend_q <= 1'b0;
    end else if (set_i) begin
      txen_o      <= 1'b1;
      stop_pend_q <= 1'b0;
    end else if (clr_i) begin
      if (in_frame_i && !frame_end_i) stop_pend_q <= 1'b1;
      else                            txen_o      <= 1'b0;
    end else if (stop_pend_q && frame_end_i) begin
      txen_o      <= 1'b0;
      stop_pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tx_stat_tracker.sv
module tx_stat_tracker
  import tx_stat_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int MAX_FRAME_BYTES = 1518,
  parameter int EARLY_IFG_BYTES = 80,
  parameter int LATE_COL_BYTES = 64,
  parameter int MAX_COL = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 frame_start_i,
  input  logic                 frame_end_i,
  input  logic                 collision_i,
  input  logic                 preamble_end_i,
  input  logic                 carrier_i,
  input  logic                 mon_carrier_i,
  input  logic                 defer_i,
  input  logic                 ifg_i,
  input  logic                 bcast_i,
  input  logic                 mcast_i,
  input  logic                 full_duplex_i,
  input  logic                 sqe_test_en_i,
  input  logic                 sqe_pulse_i,
  input  logic [4*NUM_CNT-1:0] evt_counts_i,
  input  logic                 cnt_read_i,
  input  logic                 txen_set_i,
  input  logic                 txen_clr_i,
  input  logic                 link_ni,
  output logic [15:0]          status_o,
  output logic [15:0]          snap_o,
  output logic                 snap_valid_o,
  output logic                 txen_o,
  output logic                 jam_o,
  output logic                 link_irq_o
);
  localparam int EXC_DEF_BYTES = 2 * MAX_FRAME_BYTES;
  localparam int BW = $clog2(LATE_COL_BYTES + 2);
  localparam int DW = $clog2(EXC_DEF_BYTES + 2);
  localparam int GW = $clog2(EARLY_IFG_BYTES + 1);

  logic          in_frame_q, frame_abort_q, sqe_seen_q, any_max_q, link_q;
  logic [BW-1:0] frame_bytes;
  logic [DW-1:0] defer_bytes;
  logic [GW-1:0] ifg_bytes;
  logic          multi_set, col16_set, late_set, lost_set, abort_now, fatal;
  logic [NUM_CNT-1:0] cnt_hit;
  logic          any_max;
  logic [STICKY_N-1:0] sticky_q, set_v, clr_v, sticky_pre;
  stat_word_t    snap_q;
  logic          snap_valid_q, irq_q;

  // byte-time counters
  sat_tick_cnt #(.MAX(LATE_COL_BYTES + 1)) u_frame_cnt (
    .clk_i, .rst_ni, .clr_i(frame_start_i),
    .en_i(tick_i && in_frame_q), .cnt_o(frame_bytes));

  sat_tick_cnt #(.MAX(EXC_DEF_BYTES + 1)) u_defer_cnt (
    .clk_i, .rst_ni, .clr_i(frame_end_i),
    .en_i(tick_i && defer_i), .cnt_o(defer_bytes));

  sat_tick_cnt #(.MAX(EARLY_IFG_BYTES)) u_ifg_cnt (
    .clk_i, .rst_ni, .clr_i(!ifg_i),
    .en_i(tick_i && ifg_i), .cnt_o(ifg_bytes));

  tx_col_track #(.LATE_COL_BYTES(LATE_COL_BYTES), .MAX_COL(MAX_COL)) u_col (
    .clk_i, .rst_ni, .frame_start_i, .in_frame_i(in_frame_q),
    .collision_i, .frame_bytes_i(frame_bytes),
    .multi_set_o(multi_set), .col16_set_o(col16_set),
    .late_set_o(late_set), .jam_o);

  assign lost_set  = preamble_end_i && mon_carrier_i && !carrier_i;
  assign abort_now = late_set || lost_set || col16_set;
  assign fatal     = lost_set || col16_set || jam_o;

  tx_txen_ctl u_txen (
    .clk_i, .rst_ni, .set_i(txen_set_i), .clr_i(txen_clr_i),
    .fatal_i(fatal), .in_frame_i(in_frame_q),
    .frame_end_i, .txen_o);

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt_hit
    assign cnt_hit[k] = (evt_counts_i[4*k +: 4] == 4'hF);
  end
  assign any_max = |cnt_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q    <= 1'b0;
      frame_abort_q <= 1'b0;
      sqe_seen_q    <= 1'b0;
      any_max_q     <= 1'b0;
    end else begin
      any_max_q <= any_max;
      if (frame_start_i)    in_frame_q <= 1'b1;
      else if (frame_end_i) in_frame_q <= 1'b0;
      if (frame_start_i)    frame_abort_q <= 1'b0;
      else if (abort_now)   frame_abort_q <= 1'b1;
      if (frame_start_i)    sqe_seen_q <= 1'b0;
      else if (sqe_pulse_i) sqe_seen_q <= 1'b1;
    end
  end

  always_comb begin
    set_v = '0;
    clr_v = '0;
    set_v[B_OK]    = frame_end_i && !frame_abort_q && !abort_now;
    clr_v[B_OK]    = frame_start_i;
    set_v[B_MULTI] = multi_set;
    clr_v[B_MULTI] = set_v[B_OK];
    set_v[B_BCAST] = frame_end_i && bcast_i;
    clr_v[B_BCAST] = frame_start_i;
    set_v[B_MCAST] = frame_end_i && mcast_i;
    clr_v[B_MCAST] = frame_start_i;
    set_v[B_DEFER] = ifg_i && carrier_i && (ifg_bytes < GW'(EARLY_IFG_BYTES)) && !frame_end_i;
    clr_v[B_DEFER] = frame_end_i;
    set_v[B_EXCDF] = (defer_bytes > DW'(EXC_DEF_BYTES)) && !frame_end_i;
    clr_v[B_EXCDF] = frame_end_i;
    set_v[B_LATE]  = late_set;
    clr_v[B_LATE]  = txen_set_i;
    set_v[B_LOST]  = lost_set;
    clr_v[B_LOST]  = txen_set_i;
    set_v[B_COL16] = col16_set;
    clr_v[B_COL16] = txen_set_i;
    set_v[B_SQE]   = frame_end_i && !full_duplex_i && sqe_test_en_i &&
                     !sqe_seen_q && !sqe_pulse_i;
    clr_v[B_SQE]   = txen_set_i;
    set_v[B_ROLL]  = any_max && !any_max_q;
    clr_v[B_ROLL]  = cnt_read_i;
  end

  assign sticky_pre = sticky_q | set_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sticky_q     <= '0;
      snap_q       <= '0;
      snap_valid_q <= 1'b0;
      link_q       <= 1'b0;
      irq_q        <= 1'b0;
    end else begin
      sticky_q     <= (sticky_q & ~clr_v) | set_v;
      snap_valid_q <= frame_end_i;
      if (frame_end_i) snap_q <= {3'b000, txen_o, link_q, sticky_pre};
      link_q <= !link_ni;
      irq_q  <= (!link_ni) != link_q;
    end
  end

  assign status_o     = {3'b000, txen_o, link_q, sticky_q};
  assign snap_o       = snap_q;
  assign snap_valid_o = snap_valid_q;
  assign link_irq_o   = irq_q;
endmodule

// File: rtl/tx_stat_tracker_chk.sv
module tx_stat_tracker_chk
  import tx_stat_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        frame_start_i,
  input logic        frame_end_i,
  input logic        txen_set_i,
  input logic        cnt_read_i,
  input logic [15:0] status_o,
  input logic        snap_valid_o,
  input logic        txen_o,
  input logic        jam_o,
  input logic        link_irq_o
);
  p_link_irq_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_irq_o |-> status_o[B_LINK] != $past(status_o[B_LINK]));

  p_roll_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[B_ROLL] && !cnt_read_i) |=> status_o[B_ROLL]);

  p_fatal_txen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(status_o[B_LOST]) || $rose(status_o[B_COL16])) |-> !txen_o);

  p_lost_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(status_o[B_LOST]) && !$past(txen_set_i)) |-> status_o[B_LOST]);

  p_late_jam_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[B_LATE]) |-> jam_o);

  p_jam_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jam_o |=> !txen_o);

  p_snap_strobe_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(frame_end_i) && $past(rst_ni)) |-> snap_valid_o);

  p_snap_cause_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_valid_o |-> $past(frame_end_i));

  p_ok_clear_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(frame_start_i) && !$past(frame_end_i) && $past(rst_ni)) |-> !status_o[B_OK]);
endmodule

bind tx_stat_tracker tx_stat_tracker_chk u_chk (.*);

// File: tb/tx_stat_tracker_tb_top.sv
module tx_stat_tracker_tb_top;
  import tx_stat_pkg::*;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b1;
  logic frame_start_i = 0, frame_end_i = 0, collision_i = 0, preamble_end_i = 0;
  logic carrier_i = 0, mon_carrier_i = 0, defer_i = 0, ifg_i = 0;
  logic bcast_i = 0, mcast_i = 0, full_duplex_i = 0, sqe_test_en_i = 0, sqe_pulse_i = 0;
  logic [15:0] evt_counts_i = '0;
  logic cnt_read_i = 0, txen_set_i = 0, txen_clr_i = 0, link_ni = 1;
  logic [15:0] status_o, snap_o;
  logic snap_valid_o, txen_o, jam_o, link_irq_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  tx_stat_tracker dut_i (.*);

  task automatic step(int n = 1);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start_frame();
    frame_start_i = 1; step(); frame_start_i = 0;
  endtask
  task automatic end_frame();
    frame_end_i = 1; step(); frame_end_i = 0;
  endtask
  task automatic collide();
    collision_i = 1; step(); collision_i = 0;
  endtask
  task automatic set_en();
    txen_set_i = 1; step(); txen_set_i = 0;
  endtask

  task automatic t_reset();
    step(3);
    chk("R1 status", status_o, 0);
    chk("R1 txen", txen_o, 0);
    chk("R1 snap_valid", snap_valid_o, 0);
    chk("R1 irq", link_irq_o, 0);
    rst_ni = 1; step();
    chk("R14 reserved", status_o[15:13], 0);
  endtask

  task automatic t_link();
    link_ni = 0; step();
    chk("R2 link up", status_o[B_LINK], 1);
    chk("R2 irq", link_irq_o, 1);
    step();
    chk("R2 irq one cycle", link_irq_o, 0);
    link_ni = 1; step();
    chk("R2 link down", status_o[B_LINK], 0);
    chk("R2 irq down", link_irq_o, 1);
    step();
  endtask

  task automatic t_good_frame();
    set_en();
    chk("R11 txen set", txen_o, 1);
    start_frame();
    collide(); step(); collide();
    chk("R9 multi", status_o[B_MULTI], 1);
    bcast_i = 1; end_frame(); bcast_i = 0;
    chk("R12 snap valid", snap_valid_o, 1);
    chk("R12 snap fields", snap_o[3:0], 4'b0111);
    chk("R12 snap txen", snap_o[B_TXEN], 1);
    chk("R13 ok", status_o[B_OK], 1);
    chk("R9 multi cleared", status_o[B_MULTI], 0);
    chk("R8 bcast", status_o[B_BCAST], 1);
    start_frame();
    chk("R12 snap one cycle", snap_valid_o, 0);
    chk("R13 ok cleared", status_o[B_OK], 0);
    chk("R8 bcast cleared", status_o[B_BCAST], 0);
    mcast_i = 1; end_frame(); mcast_i = 0;
    chk("R8 mcast", status_o[3:2], 2'b10);
  endtask

  task automatic t_graceful();
    start_frame(); step(3);
    txen_clr_i = 1; step(); txen_clr_i = 0;
    step(2);
    chk("R11 frame continues", txen_o, 1);
    end_frame();
    chk("R11 stop at end", txen_o, 0);
    set_en();
    txen_clr_i = 1; step(); txen_clr_i = 0;
    chk("R11 idle stop", txen_o, 0);
  endtask

  task automatic t_late();
    set_en();
    start_frame(); step(70);
    collide();
    chk("R7 jam", jam_o, 1);
    chk("R7 late bit", status_o[B_LATE], 1);
    chk("R7 txen still", txen_o, 1);
    step();
    chk("R7 jam one cycle", jam_o, 0);
    chk("R7 txen dropped", txen_o, 0);
    end_frame();
    chk("R13 no ok after abort", status_o[B_OK], 0);
    chk("R12 snap late", snap_o[B_LATE], 1);
    set_en();
    chk("R6 late cleared by set", status_o[B_LATE], 0);
    start_frame(); step(10); collide();
    chk("R7 early collision", status_o[B_LATE] | jam_o, 0);
    end_frame();
  endtask

  task automatic t_col16();
    set_en();
    start_frame();
    for (int i = 0; i < 15; i++) collide();
    chk("R6 col15 no stop", {status_o[B_COL16], txen_o}, 2'b01);
    collide();
    chk("R6 col16", status_o[B_COL16], 1);
    chk("R6 col16 txen", txen_o, 0);
    end_frame();
    chk("R6 col16 sticky", status_o[B_COL16], 1);
    set_en();
    chk("R6 col16 cleared", status_o[B_COL16], 0);
  endtask

  task automatic t_lost();
    mon_carrier_i = 0; carrier_i = 0;
    preamble_end_i = 1; step(); preamble_end_i = 0;
    chk("R6 lost ignored unmonitored", {status_o[B_LOST], txen_o}, 2'b01);
    mon_carrier_i = 1;
    preamble_end_i = 1; step(); preamble_end_i = 0;
    chk("R6 lost", {status_o[B_LOST], txen_o}, 2'b10);
    step(3);
    chk("R6 lost sticky", status_o[B_LOST], 1);
    set_en();
    chk("R6 lost cleared", {status_o[B_LOST], txen_o}, 2'b01);
    mon_carrier_i = 0;
  endtask

  task automatic t_defer();
    ifg_i = 1; carrier_i = 1; step();
    ifg_i = 0; carrier_i = 0;
    chk("R5 deferred", status_o[B_DEFER], 1);
    start_frame(); end_frame();
    chk("R5 deferred cleared", status_o[B_DEFER], 0);
    ifg_i = 1; step(85);
    carrier_i = 1; step();
    ifg_i = 0; carrier_i = 0;
    chk("R5 late carrier ignored", status_o[B_DEFER], 0);
    defer_i = 1; step(3036); defer_i = 0; step(2);
    chk("R4 at limit", status_o[B_EXCDF], 0);
    defer_i = 1; step(); defer_i = 0; step(2);
    chk("R4 over limit", status_o[B_EXCDF], 1);
    end_frame();
    chk("R4 cleared", status_o[B_EXCDF], 0);
  endtask

  task automatic t_sqe();
    full_duplex_i = 0; sqe_test_en_i = 1;
    start_frame(); end_frame();
    chk("R10 sqe set", status_o[B_SQE], 1);
    set_en();
    chk("R10 sqe cleared", status_o[B_SQE], 0);
    start_frame(); sqe_pulse_i = 1; step(); sqe_pulse_i = 0; end_frame();
    chk("R10 pulse seen", status_o[B_SQE], 0);
    full_duplex_i = 1;
    start_frame(); end_frame();
    chk("R10 full duplex", status_o[B_SQE], 0);
    full_duplex_i = 0; sqe_test_en_i = 0;
  endtask

  task automatic t_roll();
    evt_counts_i = 16'h00E0; step();
    chk("R3 below max", status_o[B_ROLL], 0);
    evt_counts_i = 16'h00F0; step();
    chk("R3 rollover", status_o[B_ROLL], 1);
    step(2);
    chk("R3 held", status_o[B_ROLL], 1);
    cnt_read_i = 1; step(); cnt_read_i = 0; step();
    chk("R3 read clears", status_o[B_ROLL], 0);
    evt_counts_i = 16'h0000; step();
    evt_counts_i = 16'hF000; step();
    chk("R3 new max", status_o[B_ROLL], 1);
    chk("R14 reserved", status_o[15:13], 0);
    chk("R14 snap reserved", snap_o[15:13], 0);
  endtask

  initial begin
    t_reset();
    t_link();
    t_good_frame();
    t_graceful();
    t_late();
    t_col16();
    t_lost();
    t_defer();
    t_sqe();
    t_roll();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<50000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule